// File: doc/BRIEF.md
# Byte-Framed SPI Register Slave

This block is the serial control port of a device that keeps 8-bit registers and 16-bit RAM words. A host on a four-wire SPI bus (clock, active-low select, data in, data out) sends a control byte, then an address byte, then one data byte for a register or two for a RAM word. The block turns each finished frame into a single-cycle read or write strobe toward the storage next to it. Read data returns on SDO, most significant bit first. A pass-through output repeats the incoming serial stream one SCLK period late, so up to eight devices can be chained on one bus.

All SPI pins are oversampled in the system clock domain through synchronisers. The incoming bit is taken on the rising edge of SCLK, and SDO changes on the falling edge. SCLK must run slowly enough that each half period lasts at least eight system clocks. The host can frame each byte with its own select pulse while the clock runs freely. It can hold select low for a whole frame with a clock that idles high. It can also move two bytes per select pulse, as a 16-bit controller does. When select is asserted while a byte is only partly shifted in, the frame logic returns to waiting for a control byte. This is how a host regains byte alignment.

Top module: `spi_regport`

## Requirements
- R1: After a synchronous reset, sdo_oe_o, sdo_o and thru_o are 0 and no access strobe is raised until a frame completes.
- R2: Control byte bit 7 = 1 selects a read and bit 6 = 1 selects a RAM word. A register frame carries one data byte and a RAM frame carries two. Every byte is shifted most significant bit first.
- R3: A write frame for this device raises acc_wr_o for exactly one cycle once its last data bit arrives. A RAM write places its first data byte in acc_wdata_o[15:8] and its second in [7:0]. A register write places its byte in [7:0] with [15:8] = 0.
- R4: Address byte bit 7 is ignored: acc_addr_o carries bits 6:0 of the address byte.
- R5: A read frame for this device raises acc_rd_o for one cycle once the address byte is complete. It takes acc_rdata_i in the cycle after the strobe: all 16 bits for RAM, bits 7:0 for a register. It shifts that value out on sdo_o, MSB first, with each bit changing on an SCLK falling edge.
- R6: sdo_oe_o is 1 only while the data bytes of a read addressed to this device are being shifted out, and it drops within a few system clocks of select going high. While it is 0, sdo_o is 0.
- R7: A frame whose control bits 3:0 differ from sel_id_i raises no strobe and never enables SDO.
- R8: If select is asserted while the count of bits received in the current byte is not zero, the partial bits are discarded and the next byte is taken as a control byte.
- R9: A frame gives the same result whether select is pulsed per byte, held for the whole frame, or pulsed once per two bytes.
- R10: On every SCLK rising edge while select is low, thru_o takes the SDI value sampled on that edge, so it repeats SDI one SCLK period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_id_i | input | 4 | Device/channel number this block answers to |
| sclk_i | input | 1 | SPI serial clock |
| cs_n_i | input | 1 | SPI select, active low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| thru_o | output | 1 | SDI repeated one SCLK period late for the next device in the chain |
| acc_rd_o | output | 1 | One-cycle read strobe |
| acc_wr_o | output | 1 | One-cycle write strobe |
| acc_ram_o | output | 1 | 1 when the strobe targets a RAM word, 0 for a register |
| acc_addr_o | output | 7 | Access address |
| acc_wdata_o | output | 16 | Write data |
| acc_rdata_i | input | 16 | Read data, valid the cycle after acc_rd_o |

## Verification
On a single SCLK rising edge the frame logic can complete a byte and issue a strobe, and in the same system cycle the chain output latches the bit that just arrived. Every frame in the table therefore also checks that thru_o, sampled before each rising edge, equals the bit driven one edge earlier. Read frames are judged on the returned word and on SDO being enabled for exactly the data bits. A second pair is a byte boundary that coincides with a select edge: per-byte and per-two-byte select pulses must not reset the frame, while a select edge after three stray bits must resynchronise it, judged by the address and data of the write that follows.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_ADDR = 2'd1,
    PH_DHI  = 2'd2,
    PH_DLO  = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_assert,
  output logic cs_active,
  output logic sdi_s
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_q, csn_q, sdi_q;
  logic sclk_d, csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '1;
      csn_q  <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b1;
      csn_d  <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk_i};
      csn_q  <= {csn_q[TOP-1:0], cs_n_i};
      sdi_q  <= {sdi_q[TOP-1:0], sdi_i};
      sclk_d <= sclk_q[TOP];
      csn_d  <= csn_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_q[TOP] & sclk_d;
  assign cs_active = ~csn_q[TOP];
  assign cs_assert = ~csn_q[TOP] & csn_d;
  assign sdi_s     = sdi_q[TOP];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   sel_id,
  input  logic              sclk_rise,
  input  logic              cs_assert,
  input  logic              cs_active,
  input  logic              sdi_s,
  output phase_e            phase_o,
  output logic              rd_hit_o,
  output logic              byte_end_o,
  output logic              acc_rd_o,
  output logic              acc_wr_o,
  output logic              acc_ram_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_wdata_o
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q, hi_q;
  logic [BYTE_W-1:0] byte_w;
  phase_e            ph_q;
  logic              rd_q, hit_q, take;

  assign take       = sclk_rise & cs_active;
  assign byte_w     = {sh_q[BYTE_W-2:0], sdi_s};
  assign byte_end_o = take & (bit_q == CNT_W'(BYTE_W - 1));
  assign phase_o    = ph_q;
  assign rd_hit_o   = rd_q & hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q       <= '0;
      sh_q        <= '0;
      hi_q        <= '0;
      ph_q        <= PH_CTRL;
      rd_q        <= 1'b0;
      hit_q       <= 1'b0;
      acc_rd_o    <= 1'b0;
      acc_wr_o    <= 1'b0;
      acc_ram_o   <= 1'b0;
      acc_addr_o  <= '0;
      acc_wdata_o <= '0;
    end else begin
      acc_rd_o <= 1'b0;
      acc_wr_o <= 1'b0;
      if (cs_assert && bit_q != '0) begin
        bit_q <= '0;
        ph_q  <= PH_CTRL;
      end else if (take) begin
        sh_q  <= byte_w;
        bit_q <= bit_q + 1'b1;
        if (byte_end_o) begin
          unique case (ph_q)
            PH_CTRL: begin
              rd_q      <= byte_w[7];
              acc_ram_o <= byte_w[6];
              hit_q     <= (byte_w[ID_W-1:0] == sel_id);
              ph_q      <= PH_ADDR;
            end
            PH_ADDR: begin
              acc_addr_o <= byte_w[ADDR_W-1:0];
              acc_rd_o   <= rd_q & hit_q;
              ph_q       <= acc_ram_o ? PH_DHI : PH_DLO;
            end
            PH_DHI: begin
              hi_q <= byte_w;
              ph_q <= PH_DLO;
            end
            PH_DLO: begin
              acc_wr_o    <= ~rd_q & hit_q;
              acc_wdata_o <= acc_ram_o ? {hi_q, byte_w} : {{PAD_W{1'b0}}, byte_w};
              ph_q        <= PH_CTRL;
            end
          endcase
        end
      end
    end
  end

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd_o && acc_wr_o));
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    acc_wr_o |=> !acc_wr_o);
  p_reg_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_wr_o && !acc_ram_o) |-> (acc_wdata_o[DATA_W-1:BYTE_W] == '0));
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    acc_rd_o |=> !acc_rd_o);
  p_softreset_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_assert && bit_q != '0) |=> (ph_q == PH_CTRL && bit_q == '0));
endmodule

// File: rtl/spi_sdo_drv.sv
module spi_sdo_drv
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_active,
  input  logic              sdi_s,
  input  phase_e            phase,
  input  logic              rd_hit,
  input  logic              byte_end,
  input  logic              rd_stb,
  input  logic              ram_sel,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              thru_o
);
  logic [DATA_W-1:0] rsh_q;
  logic              ld_q, in_data;

  assign in_data = (phase == PH_DHI) || (phase == PH_DLO);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh_q    <= '0;
      ld_q     <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
      thru_o   <= 1'b0;
    end else begin
      ld_q <= rd_stb;
      if (ld_q) begin
        rsh_q <= ram_sel ? rdata : {rdata[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
      end else if (sclk_fall && cs_active && in_data && rd_hit) begin
        rsh_q <= {rsh_q[DATA_W-2:0], 1'b0};
      end
      if (!cs_active || byte_end) begin
        sdo_oe_o <= 1'b0;
        sdo_o    <= 1'b0;
      end else if (sclk_fall && in_data && rd_hit) begin
        sdo_oe_o <= 1'b1;
        sdo_o    <= rsh_q[DATA_W-1];
      end
      if (sclk_rise && cs_active) thru_o <= sdi_s;
    end
  end

  p_oe_dataphase_r6: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> (in_data && rd_hit));
  p_cs_release_r6: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !sdo_oe_o);
  p_quiet_low_r6: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe_o |-> !sdo_o);
  p_thru_r10: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && cs_active) |=> (thru_o == $past(sdi_s)));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int ID_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   sel_id_i,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              thru_o,
  output logic              acc_rd_o,
  output logic              acc_wr_o,
  output logic              acc_ram_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [DATA_W-1:0] acc_wdata_o,
  input  logic [DATA_W-1:0] acc_rdata_i
);
  logic   s_rise, s_fall, s_assert, s_active, s_sdi;
  logic   rd_hit, byte_end;
  phase_e phase;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
    .sclk_rise(s_rise), .sclk_fall(s_fall), .cs_assert(s_assert),
    .cs_active(s_active), .sdi_s(s_sdi)
  );

  spi_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_fsm (
    .clk(clk), .rst(rst), .sel_id(sel_id_i), .sclk_rise(s_rise),
    .cs_assert(s_assert), .cs_active(s_active), .sdi_s(s_sdi),
    .phase_o(phase), .rd_hit_o(rd_hit), .byte_end_o(byte_end),
    .acc_rd_o(acc_rd_o), .acc_wr_o(acc_wr_o), .acc_ram_o(acc_ram_o),
    .acc_addr_o(acc_addr_o), .acc_wdata_o(acc_wdata_o)
  );

  spi_sdo_drv #(.DATA_W(DATA_W)) u_sdo (
    .clk(clk), .rst(rst), .sclk_rise(s_rise), .sclk_fall(s_fall),
    .cs_active(s_active), .sdi_s(s_sdi), .phase(phase), .rd_hit(rd_hit),
    .byte_end(byte_end), .rd_stb(acc_rd_o), .ram_sel(acc_ram_o),
    .rdata(acc_rdata_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .thru_o(thru_o)
  );
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb_top;
  localparam int HALF = 8;
  localparam logic [3:0] SEL = 4'h5;
  localparam int NV = 10;
  // {mode[1:0], ctrl[7:0], addr[7:0], wdata[15:0], expected read[15:0]}
  // mode 0: select per byte, 1: select per frame, 2: select per two bytes
  localparam logic [49:0] VEC [NV] = '{
    {2'd1, 8'h05, 8'h12, 16'h00A5, 16'h0000},
    {2'd0, 8'h85, 8'h12, 16'h0000, 16'h00A5},
    {2'd2, 8'h45, 8'h30, 16'hBEEF, 16'h0000},
    {2'd1, 8'hC5, 8'h30, 16'h0000, 16'hBEEF},
    {2'd0, 8'h05, 8'h83, 16'h003C, 16'h0000},
    {2'd2, 8'h85, 8'h03, 16'h0000, 16'h003C},
    {2'd1, 8'h07, 8'h12, 16'h0011, 16'h0000},
    {2'd1, 8'h85, 8'h12, 16'h0000, 16'h00A5},
    {2'd0, 8'h45, 8'h7F, 16'h1234, 16'h0000},
    {2'd2, 8'hC5, 8'h7F, 16'h0000, 16'h1234}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, thru, acc_rd, acc_wr, acc_ram;
  logic [6:0] acc_addr;
  logic [15:0] acc_wdata, acc_rdata;
  logic [7:0]  reg_mem [128];
  logic [15:0] ram_mem [128];
  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  int oe_bad = 0, thru_bad = 0;
  logic [6:0] last_addr;
  logic [15:0] last_data;
  logic last_ram;
  bit have_prev = 0, prev_bit = 0;

  always #2 clk = ~clk;

  spi_regport dut_i (
    .clk(clk), .rst(rst), .sel_id_i(SEL), .sclk_i(sclk), .cs_n_i(cs_n),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .thru_o(thru),
    .acc_rd_o(acc_rd), .acc_wr_o(acc_wr), .acc_ram_o(acc_ram),
    .acc_addr_o(acc_addr), .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata)
  );

  initial begin
    for (int i = 0; i < 128; i++) begin reg_mem[i] = 8'h00; ram_mem[i] = 16'h0000; end
  end

  always @(posedge clk) begin
    if (rst) acc_rdata <= 16'h0;
    else if (acc_rd) acc_rdata <= acc_ram ? ram_mem[acc_addr] : {8'h00, reg_mem[acc_addr]};
    if (!rst && acc_wr) begin
      wr_cnt <= wr_cnt + 1;
      last_addr <= acc_addr; last_data <= acc_wdata; last_ram <= acc_ram;
      if (acc_ram) ram_mem[acc_addr] <= acc_wdata;
      else reg_mem[acc_addr] <= acc_wdata[7:0];
    end
    if (!rst && acc_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, input bit exp_oe, output bit rx);
    sclk = 1'b0; sdi = b;
    repeat (HALF) @(negedge clk);
    rx = sdo;
    if (sdo_oe !== exp_oe) oe_bad++;
    if (have_prev && thru !== prev_bit) thru_bad++;
    sclk = 1'b1; prev_bit = b; have_prev = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_txn(input logic [1:0] mode, input logic [7:0] ctrl, input logic [7:0] addr,
                        input logic [15:0] wd, output logic [15:0] rd);
    logic [7:0] tx [4];
    int nb;
    bit hit, rx;
    hit = (ctrl[3:0] == SEL);
    nb = ctrl[6] ? 4 : 3;
    tx[0] = ctrl; tx[1] = addr;
    tx[2] = ctrl[6] ? wd[15:8] : wd[7:0]; tx[3] = wd[7:0];
    rd = '0;
    for (int b = 0; b < nb; b++) begin
      if (mode == 0 || (mode == 1 && b == 0) || (mode == 2 && b % 2 == 0)) begin
        cs_n = 1'b0; repeat (HALF) @(negedge clk);
      end
      for (int i = 7; i >= 0; i--) begin
        send_bit(tx[b][i], ctrl[7] && hit && b >= 2, rx);
        if (b >= 2) rd = {rd[14:0], rx};
      end
      if (mode == 0 || b == nb - 1 || (mode == 2 && b % 2 == 1)) begin
        cs_n = 1'b1; repeat (HALF) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=hang expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] rdv;
    int w0, r0;
    logic [1:0] md; logic [7:0] ct, ad; logic [15:0] wd, ex;
    bit hb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", sdo_oe, 1'b0);
    check("R1 sdo", sdo, 1'b0);
    check("R1 thru", thru, 1'b0);
    check("R1 strobes", wr_cnt + rd_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      {md, ct, ad, wd, ex} = VEC[v];
      hb = (ct[3:0] == SEL);
      w0 = wr_cnt; r0 = rd_cnt; oe_bad = 0; thru_bad = 0;
      do_txn(md, ct, ad, wd, rdv);
      check("R10 thru relay", thru_bad, 0);
      check("R6 oe window", oe_bad, 0);
      if (ct[7]) begin
        check("R5 read strobes", rd_cnt - r0, hb ? 1 : 0);
        if (hb) check(ct[6] ? "R2 R9 ram read" : "R5 R9 reg read",
                      ct[6] ? rdv : {8'h00, rdv[7:0]}, ex);
      end else begin
        check(hb ? "R3 write strobe" : "R7 id miss write", wr_cnt - w0, hb ? 1 : 0);
        if (hb) begin
          check("R4 address", last_addr, ad[6:0]);
          check("R3 wdata", last_data, ct[6] ? wd : {8'h00, wd[7:0]});
          check("R2 ram flag", last_ram, ct[6]);
        end
      end
    end

    // R7: read to another id leaves SDO disabled
    oe_bad = 0; r0 = rd_cnt;
    do_txn(2'd1, 8'h86, 8'h12, 16'h0, rdv);
    check("R7 miss read oe", oe_bad, 0);
    check("R7 miss read strobe", rd_cnt - r0, 0);

    // R8: three stray bits, select released and reasserted, then a write
    begin
      bit rx;
      cs_n = 1'b0; repeat (HALF) @(negedge clk);
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0, rx);
      cs_n = 1'b1; repeat (HALF) @(negedge clk);
    end
    w0 = wr_cnt;
    do_txn(2'd0, 8'h05, 8'h20, 16'h005A, rdv);
    check("R8 resync strobe", wr_cnt - w0, 1);
    check("R8 resync addr", last_addr, 7'h20);
    check("R8 resync data", last_data, 16'h005A);
    check("R6 idle oe", sdo_oe, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule